// File: doc/BRIEF.md
# System-Management Memory Access Controller

This block decides where each memory access lands while a processor runs in normal mode or in system-management mode. It holds two 8-bit control registers, one governing a legacy low window and its optional high alias and one governing a protected segment just below the top of low memory. It also holds a 16-bit register through which firmware learns the size of the extended segment. Software writes the registers through a simple write port. Each access address, together with a management-mode flag, is turned combinationally into a route code and an effective RAM address.

The legacy window covers 0xA0000..0xBFFFF. Its high alias covers the 128 KB starting at 0xFEDA0000 and maps onto the same RAM. The protected segment ends at the configured low-memory top, and its size is picked by the segment register. A sticky lock bit freezes the configuration until reset.

Top module: `smm_access_ctl`

## Requirements
- R1: After reset the legacy control register reads 0x02, the segment control register reads 0x00, and the extended-size register reads 0xFFFF (the query value) when EXT_MB is nonzero, or 0x0000 otherwise.
- R2: Register select 0 addresses the legacy control register, 1 the segment control register and 2 the extended-size register. While unlocked, only bits 6..3 of the legacy register can be written (6 open, 5 close, 4 lock, 3 global enable), and only bits 7 (high enable), 2..1 (size select) and 0 (segment enable) of the segment register. All other bits keep their values.
- R3: Any write that leaves the lock bit (legacy bit 4) set also clears the open bit, even when the same write sets open. Once locked, only the close bit of the legacy register stays writable and the segment register ignores writes. This holds until reset.
- R4: For a normal access to the legacy window with open set, the route is PCI when high enable is set and RAM otherwise.
- R5: With open clear, a normal access to the legacy window routes to PCI. A normal access to the high alias gets the default route.
- R6: With open and high enable both set, a normal access to the high alias routes to RAM at address minus 0xFEDA0000 plus 0xA0000.
- R7: A management-mode access with global enable set reaches RAM in the legacy window when high enable is clear, and in the high alias (remapped as in R6) when it is set. Any other management-mode access to those windows is decided as a normal access would be.
- R8: The segment size is 0 when segment enable is clear. When it is set, size select 0, 1, 2 and 3 give 1 MB, 2 MB, 8 MB and EXT_MB MB respectively.
- R9: A normal access in [low_top - size, low_top) gets route 2 (all-ones read, write dropped). A management-mode access there routes to RAM at the unchanged address.
- R10: Writing 0xFFFF to the extended-size register stores EXT_MB. Any other written value is stored as given.
- R11: Route codes are 0 RAM, 1 PCI and 2 all-ones. Any access not claimed by a window routes to RAM below low_top and to PCI at or above it. Outside the alias, the RAM address equals the access address.
- R12: The route reflects a register write from the cycle after the write's clock edge. In the write's own cycle it still reflects the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 legacy, 1 segment, 2 extended size) |
| wr_data | input | 16 | Write data (8-bit registers use bits 7..0) |
| acc_addr | input | ADDR_W | Access address |
| acc_smm | input | 1 | Access issued in management mode |
| low_top | input | ADDR_W | Top of low memory |
| route | output | 2 | Route code |
| ram_addr | output | ADDR_W | Effective RAM address |
| ctl_legacy | output | 8 | Legacy control register contents |
| ctl_seg | output | 8 | Segment control register contents |
| ext_size | output | 16 | Extended-size register contents |

## Verification
Two things can happen in one cycle: a write can set the lock and the open bit together, and a write can change the segment while an access is being routed. The bench gives the lock and the open bit in a single write and expects open to read back clear. It then holds an access steady across a segment-enable write and samples the route before and after the clock edge. The old route must appear in the write's cycle and the all-ones route afterwards.

// File: rtl/smm_pkg.sv
package smm_pkg;
   typedef enum logic [1:0] {
      ROUTE_RAM  = 2'd0,
      ROUTE_PCI  = 2'd1,
      ROUTE_ONES = 2'd2
   } route_e;

   localparam int LB_OPEN  = 6;
   localparam int LB_CLOSE = 5;
   localparam int LB_LOCK  = 4;
   localparam int LB_GEN   = 3;
   localparam int SB_HIGH  = 7;
   localparam int SB_EN    = 0;

   localparam logic [15:0] EXT_QUERY = 16'hFFFF;
   localparam int          EXT_MAX   = 4095;
endpackage

// File: rtl/smm_ctl_regs.sv
module smm_ctl_regs
   import smm_pkg::*;
#(
   parameter int EXT_MB = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_sel,
   input  logic [15:0] wr_data,
   output logic [7:0]  leg_q,
   output logic [7:0]  seg_q,
   output logic [15:0] ext_q
);
   localparam logic [7:0] LEG_RST     = 8'h02;
   localparam logic [7:0] LEG_MASK    = 8'h78;
   localparam logic [7:0] LEG_MASK_LK = 8'h20;
   localparam logic [7:0] SEG_MASK    = 8'h87;
   localparam logic [7:0] SEG_MASK_LK = 8'h00;

   logic       locked;
   logic [7:0] leg_m, seg_m, leg_nxt, seg_nxt;

   always_comb begin
      locked  = leg_q[LB_LOCK];
      leg_m   = locked ? LEG_MASK_LK : LEG_MASK;
      seg_m   = locked ? SEG_MASK_LK : SEG_MASK;
      leg_nxt = (leg_q & ~leg_m) | (wr_data[7:0] & leg_m);
      if (leg_nxt[LB_LOCK]) leg_nxt[LB_OPEN] = 1'b0;
      seg_nxt = (seg_q & ~seg_m) | (wr_data[7:0] & seg_m);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         leg_q <= LEG_RST;
         seg_q <= 8'h00;
      end else if (wr_en) begin
         if (wr_sel == 2'd0) leg_q <= leg_nxt;
         if (wr_sel == 2'd1) seg_q <= seg_nxt;
      end
   end

   generate
      if (EXT_MB > 0) begin : g_ext
         always_ff @(posedge clk) begin
            if (!rst_n)
               ext_q <= EXT_QUERY;
            else if (wr_en && wr_sel == 2'd2)
               ext_q <= (wr_data == EXT_QUERY) ? 16'(EXT_MB) : wr_data;
         end
      end else begin : g_no_ext
         assign ext_q = 16'h0000;
      end
   endgenerate
endmodule

// File: rtl/smm_seg_size.sv
module smm_seg_size
   import smm_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int EXT_MB = 16
) (
   input  logic [7:0]        seg_q,
   output logic [ADDR_W-1:0] seg_size
);
   localparam int MB_SHIFT = 20;

   logic [11:0] mb;

   always_comb begin
      unique case (seg_q[2:1])
         2'd0:    mb = 12'd1;
         2'd1:    mb = 12'd2;
         2'd2:    mb = 12'd8;
         default: mb = 12'(EXT_MB);
      endcase
      if (!seg_q[SB_EN]) mb = 12'd0;
      seg_size = ADDR_W'(mb) << MB_SHIFT;
   end
endmodule

// File: rtl/smm_router.sv
module smm_router
   import smm_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] LEG_BASE = ADDR_W'(32'h000A_0000),
   parameter logic [ADDR_W-1:0] LEG_SIZE = ADDR_W'(32'h0002_0000),
   parameter logic [ADDR_W-1:0] HI_BASE  = ADDR_W'(32'hFEDA_0000)
) (
   input  logic [7:0]        leg_q,
   input  logic [7:0]        seg_q,
   input  logic [ADDR_W-1:0] seg_size,
   input  logic [ADDR_W-1:0] low_top,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_smm,
   output route_e            route,
   output logic [ADDR_W-1:0] ram_addr
);
   localparam logic [ADDR_W-1:0] ALIAS_DELTA = HI_BASE - LEG_BASE;

   logic              in_leg, in_hi, in_seg, open, hi, gen;
   logic [ADDR_W-1:0] seg_base, alias_addr;
   route_e            nrm_route;
   logic [ADDR_W-1:0] nrm_addr;

   always_comb begin
      open       = leg_q[LB_OPEN];
      gen        = leg_q[LB_GEN];
      hi         = seg_q[SB_HIGH];
      seg_base   = low_top - seg_size;
      in_leg     = (acc_addr - LEG_BASE) < LEG_SIZE;
      in_hi      = (acc_addr - HI_BASE) < LEG_SIZE;
      in_seg     = (seg_size != '0) && ((acc_addr - seg_base) < seg_size);
      alias_addr = acc_addr - ALIAS_DELTA;

      nrm_addr = acc_addr;
      if (in_hi && open && hi) begin
         nrm_route = ROUTE_RAM;
         nrm_addr  = alias_addr;
      end else if (in_leg)
         nrm_route = (open && !hi) ? ROUTE_RAM : ROUTE_PCI;
      else if (in_seg)
         nrm_route = ROUTE_ONES;
      else
         nrm_route = (acc_addr < low_top) ? ROUTE_RAM : ROUTE_PCI;

      route    = nrm_route;
      ram_addr = nrm_addr;
      if (acc_smm) begin
         if (gen && hi && in_hi) begin
            route    = ROUTE_RAM;
            ram_addr = alias_addr;
         end else if (gen && !hi && in_leg) begin
            route    = ROUTE_RAM;
            ram_addr = acc_addr;
         end else if (in_seg) begin
            route    = ROUTE_RAM;
            ram_addr = acc_addr;
         end
      end
   end
endmodule

// File: rtl/smm_access_ctl.sv
module smm_access_ctl
   import smm_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter int                EXT_MB   = 16,
   parameter logic [ADDR_W-1:0] LEG_BASE = ADDR_W'(32'h000A_0000),
   parameter logic [ADDR_W-1:0] LEG_SIZE = ADDR_W'(32'h0002_0000),
   parameter logic [ADDR_W-1:0] HI_BASE  = ADDR_W'(32'hFEDA_0000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [15:0]       wr_data,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_smm,
   input  logic [ADDR_W-1:0] low_top,
   output logic [1:0]        route,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [7:0]        ctl_legacy,
   output logic [7:0]        ctl_seg,
   output logic [15:0]       ext_size
);
   generate
      if (EXT_MB < 0 || EXT_MB > EXT_MAX) begin : g_bad_ext
         $error("EXT_MB out of range");
      end
      if (ADDR_W < 32) begin : g_bad_w
         $error("ADDR_W must be at least 32");
      end
   endgenerate

   logic [7:0]        leg_q, seg_q;
   logic [15:0]       ext_q;
   logic [ADDR_W-1:0] seg_size;
   route_e            route_w;

   smm_ctl_regs #(.EXT_MB(EXT_MB)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .leg_q(leg_q), .seg_q(seg_q), .ext_q(ext_q)
   );

   smm_seg_size #(.ADDR_W(ADDR_W), .EXT_MB(EXT_MB)) u_size (
      .seg_q(seg_q), .seg_size(seg_size)
   );

   smm_router #(
      .ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .LEG_SIZE(LEG_SIZE), .HI_BASE(HI_BASE)
   ) u_route (
      .leg_q(leg_q), .seg_q(seg_q), .seg_size(seg_size), .low_top(low_top),
      .acc_addr(acc_addr), .acc_smm(acc_smm), .route(route_w), .ram_addr(ram_addr)
   );

   assign route      = route_w;
   assign ctl_legacy = leg_q;
   assign ctl_seg    = seg_q;
   assign ext_size   = ext_q;
endmodule

// File: rtl/smm_access_ctl_chk.sv
module smm_access_ctl_chk #(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] LEG_BASE = ADDR_W'(32'h000A_0000),
   parameter logic [ADDR_W-1:0] LEG_SIZE = ADDR_W'(32'h0002_0000),
   parameter logic [ADDR_W-1:0] HI_BASE  = ADDR_W'(32'hFEDA_0000)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [7:0]        leg_q,
   input logic [7:0]        seg_q,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_smm,
   input logic [1:0]        route,
   input logic [ADDR_W-1:0] ram_addr
);
   a_r3_open_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      leg_q[4] |-> !leg_q[6]);

   a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      leg_q[4] |=> leg_q[4]);

   a_r3_seg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      leg_q[4] |=> $stable(seg_q));

   a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
      leg_q[2:0] == 3'b010 && seg_q[6:3] == 4'd0);

   a_r9_ones_not_smm: assert property (@(posedge clk) disable iff (!rst_n)
      route == 2'd2 |-> !acc_smm);

   a_r8_no_seg_no_ones: assert property (@(posedge clk) disable iff (!rst_n)
      !seg_q[0] |-> route != 2'd2);

   a_r7_smm_high_ram: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_smm && leg_q[3] && seg_q[7] && ((acc_addr - HI_BASE) < LEG_SIZE))
      |-> (route == 2'd0 && ram_addr == acc_addr - HI_BASE + LEG_BASE));
endmodule

bind smm_access_ctl smm_access_ctl_chk #(
   .ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .LEG_SIZE(LEG_SIZE), .HI_BASE(HI_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .leg_q(leg_q), .seg_q(seg_q),
   .acc_addr(acc_addr), .acc_smm(acc_smm), .route(route), .ram_addr(ram_addr)
);

// File: tb/smm_access_ctl_test.sv
module smm_access_ctl_test;
   localparam int W = 32;
   localparam logic [1:0] RAM = 2'd0, PCI = 2'd1, ONES = 2'd2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = '0;
   logic [15:0]   wr_data = '0;
   logic [W-1:0]  acc_addr = '0;
   logic          acc_smm = 1'b0;
   logic [W-1:0]  low_top = 32'h8000_0000;
   logic [1:0]    route;
   logic [W-1:0]  ram_addr;
   logic [7:0]    ctl_legacy, ctl_seg;
   logic [15:0]   ext_size;

   int checks = 0;
   int fails  = 0;

   smm_access_ctl #(.ADDR_W(W), .EXT_MB(16)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .acc_addr(acc_addr), .acc_smm(acc_smm), .low_top(low_top),
      .route(route), .ram_addr(ram_addr),
      .ctl_legacy(ctl_legacy), .ctl_seg(ctl_seg), .ext_size(ext_size)
   );

   always #10 clk = ~clk;

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic probe(input string tag, input logic [W-1:0] a, input logic smm,
                        input logic [1:0] er, input logic [W-1:0] ea);
      @(negedge clk);
      acc_addr = a; acc_smm = smm;
      #2;
      check({tag, " route"}, W'(route), W'(er));
      if (er == RAM) check({tag, " addr"}, ram_addr, ea);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      check("R1 legacy", W'(ctl_legacy), 32'h02);
      check("R1 seg", W'(ctl_seg), 32'h00);
      check("R1 ext", W'(ext_size), 32'hFFFF);
      probe("R11 low ram", 32'h0000_1000, 1'b0, RAM, 32'h0000_1000);
      probe("R11 above top", 32'h9000_0000, 1'b0, PCI, 0);
      probe("R5 closed low", 32'h000A_0000, 1'b0, PCI, 0);
      probe("R8 seg off", 32'h7FFF_FFF0, 1'b0, RAM, 32'h7FFF_FFF0);
   endtask

   task automatic t_masks();
      wr(2'd0, 16'h00EF); check("R2 legacy mask", W'(ctl_legacy), 32'h6A);
      wr(2'd0, 16'h0000); check("R2 legacy clear", W'(ctl_legacy), 32'h02);
      wr(2'd1, 16'h00FF); check("R2 seg mask", W'(ctl_seg), 32'h87);
      wr(2'd1, 16'h0000); check("R2 seg clear", W'(ctl_seg), 32'h00);
   endtask

   task automatic t_open();
      wr(2'd0, 16'h0048); wr(2'd1, 16'h0000);
      probe("R4 open low ram", 32'h000A_0000, 1'b0, RAM, 32'h000A_0000);
      probe("R4 open top edge", 32'h000B_FFFF, 1'b0, RAM, 32'h000B_FFFF);
      probe("R11 past window", 32'h000C_0000, 1'b0, RAM, 32'h000C_0000);
      probe("R5 hi hidden", 32'hFEDA_0010, 1'b0, PCI, 0);
      wr(2'd1, 16'h0080);
      probe("R4 open hi pci", 32'h000A_0010, 1'b0, PCI, 0);
      probe("R6 alias ram", 32'hFEDA_0010, 1'b0, RAM, 32'h000A_0010);
      probe("R6 alias end", 32'hFEDC_0000, 1'b0, PCI, 0);
   endtask

   task automatic t_closed();
      wr(2'd0, 16'h0008); wr(2'd1, 16'h0080);
      probe("R5 closed low", 32'h000A_4000, 1'b0, PCI, 0);
      probe("R5 closed hi", 32'hFEDA_4000, 1'b0, PCI, 0);
      probe("R7 smm hi", 32'hFEDA_4000, 1'b1, RAM, 32'h000A_4000);
      probe("R7 smm low hi set", 32'h000A_4000, 1'b1, PCI, 0);
      wr(2'd1, 16'h0000);
      probe("R7 smm low", 32'h000A_4000, 1'b1, RAM, 32'h000A_4000);
      probe("R7 smm hi off", 32'hFEDA_4000, 1'b1, PCI, 0);
      wr(2'd0, 16'h0000);
      probe("R7 gen clear", 32'h000A_4000, 1'b1, PCI, 0);
   endtask

   task automatic t_seg();
      wr(2'd1, 16'h0001);
      probe("R9 1MB base", 32'h7FF0_0000, 1'b0, ONES, 0);
      probe("R9 below base", 32'h7FEF_FFFF, 1'b0, RAM, 32'h7FEF_FFFF);
      probe("R9 last byte", 32'h7FFF_FFFF, 1'b0, ONES, 0);
      probe("R9 at top", 32'h8000_0000, 1'b0, PCI, 0);
      probe("R9 smm ram", 32'h7FF0_0000, 1'b1, RAM, 32'h7FF0_0000);
      wr(2'd1, 16'h0003);
      probe("R8 2MB", 32'h7FE0_0000, 1'b0, ONES, 0);
      wr(2'd1, 16'h0005);
      probe("R8 8MB", 32'h7F80_0000, 1'b0, ONES, 0);
      probe("R8 8MB below", 32'h7F7F_FFFF, 1'b0, RAM, 32'h7F7F_FFFF);
      wr(2'd1, 16'h0007);
      probe("R8 ext 16MB", 32'h7F00_0000, 1'b0, ONES, 0);
      wr(2'd1, 16'h0006);
      probe("R8 enable clear", 32'h7F00_0000, 1'b0, RAM, 32'h7F00_0000);
   endtask

   task automatic t_timing();
      wr(2'd1, 16'h0000);
      @(negedge clk);
      acc_addr = 32'h7FF0_0000; acc_smm = 1'b0;
      wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h0001;
      #5;
      check("R12 before edge", W'(route), W'(RAM));
      @(posedge clk); #2;
      check("R12 after edge", W'(route), W'(ONES));
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic t_ext();
      wr(2'd2, 16'h1234); check("R10 plain", W'(ext_size), 32'h1234);
      wr(2'd2, 16'hFFFF); check("R10 query", W'(ext_size), 32'h0010);
   endtask

   task automatic t_lock();
      wr(2'd1, 16'h0080);
      wr(2'd0, 16'h0058);
      check("R3 lock clears open", W'(ctl_legacy), 32'h1A);
      wr(2'd0, 16'h0068);
      check("R3 close writable", W'(ctl_legacy), 32'h3A);
      wr(2'd0, 16'h0000);
      check("R3 lock sticky", W'(ctl_legacy), 32'h1A);
      wr(2'd1, 16'h0007);
      check("R3 seg frozen", W'(ctl_seg), 32'h80);
      do_reset();
      check("R3 reset unlocks", W'(ctl_legacy), 32'h02);
   endtask

   initial begin
      #(200000 * 20);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_masks();
      t_open();
      t_closed();
      t_seg();
      t_timing();
      t_ext();
      t_lock();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule